// File: doc/BRIEF.md
# Edge-Serviced Watchdog Timer

This block watches one service line that a processor toggles from software. Each change of level on the line counts as service, whether it rises or falls. If the line stays at one level for a set number of clock cycles, the active-low timeout flag goes low. It stays low until the next change of level on the line, or until system reset, clears the timer. The flag does not clear itself. The block never produces a reset of its own. To turn a timeout into a reset, the integrator routes the flag into the chip's reset logic.

The supply-good input forces the flag low whenever it is false, whether or not the timer has run out. When supply-good returns, the flag follows it in the same cycle, with no added delay. Loss of supply does not stop the timer and does not clear it. While system reset is active the count is held at zero, so the timeout window opens only once reset is released.

The service line is taken through a two-flop synchronizer. An edge is detected by comparing the synchronized value with the one a cycle older. The timeout length is a parameter counted in clock cycles.

Top module: `kick_watchdog`

## Requirements
- R1: With no service edge and reset inactive, `wd_ok_n` goes low at the TIMEOUT_CYCLES-th rising clock edge after the edge that last cleared the timer, and is still high one cycle earlier.
- R2: A change of `kick_i` in either direction clears the timer. The clear takes effect at the third rising clock edge after the change, and after that edge the flag is high (when supply is good).
- R3: While `sys_rst` is high, the timer is held clear and the flag is not asserted by the timer. The first rising edge with `sys_rst` high clears a flag that had already expired.
- R4: Once the timer has expired, `wd_ok_n` stays low for as long as no service edge and no reset arrives.
- R5: While `supply_ok` is low, `wd_ok_n` is low in the same cycle, with no clock edge needed. The timer keeps counting and is not cleared.
- R6: When `supply_ok` returns high and the timer has not expired, `wd_ok_n` is high in the same cycle.
- R7: When a service edge and the expiry fall on the same clock edge, the service edge wins. The timer clears, the flag stays high, and a full new window starts.
- R8: A pulse on `kick_i` that lasts two clock cycles registers both of its edges, so the next timeout is measured from the pulse's trailing edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| sys_rst | input | 1 | System reset active, synchronous, active high; holds the timer clear |
| kick_i | input | 1 | Asynchronous service line from the processor |
| supply_ok | input | 1 | High while the supply is above its threshold |
| wd_ok_n | output | 1 | Active-low timeout flag |

## Verification
The bench builds the block with TIMEOUT_CYCLES = 20, which keeps every window short. The exact cycle of expiry, a service edge landing on the expiry edge, and a supply dip in the middle of a window can therefore all be reached and checked to the cycle. The default of 1.6 s worth of cycles is only elaborated. Its behaviour differs only in the width of the counter.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  // Synchronizer depth shared by the watchdog sub-blocks
  localparam int unsigned WDG_SYNC_DEPTH = 2;

  // Counter width able to hold values 0..limit-1
  function automatic int unsigned wdg_cnt_width(input int unsigned limit);
    return (limit <= 2) ? 1 : $clog2(limit);
  endfunction
endpackage

// File: rtl/wdg_sync.sv
module wdg_sync #(
  parameter int unsigned STAGES = wdg_pkg::WDG_SYNC_DEPTH
) (
  input  logic clk,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) chain_q <= din;
    end else begin : g_multi
      always_ff @(posedge clk) chain_q <= {chain_q[STAGES-2:0], din};
    end
  endgenerate

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/wdg_edge.sv
module wdg_edge (
  input  logic clk,
  input  logic level_i,
  output logic edge_o
);
  logic prev_q;

  always_ff @(posedge clk) prev_q <= level_i;

  // Either direction of change counts as service
  assign edge_o = level_i ^ prev_q;
endmodule

// File: rtl/wdg_timer.sv
module wdg_timer #(
  parameter int unsigned LIMIT = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic clear_i,
  output logic expired_o
);
  localparam int unsigned W = wdg_pkg::wdg_cnt_width(LIMIT);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;
  logic         exp_q;

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else if (cnt_q == LAST) begin
      exp_q <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired_o = exp_q;

  // R7: a clear on the expiry edge leaves the flag deasserted
  p_kick_wins_r7: assert property (@(posedge clk) disable iff (rst)
    (clear_i && cnt_q == LAST) |=> !exp_q);

  // R4: expiry is held until a clear
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (exp_q && !clear_i) |=> exp_q);

  // R1: reaching the last count without a clear expires the timer
  p_expire_r1: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == LAST && !clear_i) |=> exp_q);
endmodule

// File: rtl/kick_watchdog.sv
module kick_watchdog #(
  parameter int unsigned TIMEOUT_CYCLES = 200_000_000,
  parameter int unsigned SYNC_STAGES    = wdg_pkg::WDG_SYNC_DEPTH
) (
  input  logic clk,
  input  logic sys_rst,
  input  logic kick_i,
  input  logic supply_ok,
  output logic wd_ok_n
);
  logic kick_sync;
  logic kick_edge;
  logic expired;

  wdg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .din (kick_i),
    .dout(kick_sync)
  );

  wdg_edge u_edge (
    .clk    (clk),
    .level_i(kick_sync),
    .edge_o (kick_edge)
  );

  wdg_timer #(.LIMIT(TIMEOUT_CYCLES)) u_timer (
    .clk      (clk),
    .rst      (sys_rst),
    .clear_i  (kick_edge),
    .expired_o(expired)
  );

  // Supply loss overrides the flag without waiting for a clock edge
  assign wd_ok_n = supply_ok & ~expired;

  // R5: a low supply always shows as an asserted flag
  p_supply_r5: assert property (@(posedge clk) disable iff (sys_rst)
    !supply_ok |-> !wd_ok_n);

  // R3: one cycle into reset, the flag follows only the supply
  p_reset_clear_r3: assert property (@(posedge clk) disable iff (1'b0)
    sys_rst |=> (wd_ok_n == supply_ok));

  // R2: a service edge leaves the flag reflecting supply alone
  p_edge_clear_r2: assert property (@(posedge clk) disable iff (sys_rst)
    kick_edge |=> (wd_ok_n == supply_ok));
endmodule

// File: tb/kick_watchdog_test.sv
module kick_watchdog_test;
  localparam int unsigned LIM = 20;
  localparam int unsigned NV  = 18;

  logic clk = 1'b0;
  logic sys_rst = 1'b1;
  logic kick_i = 1'b0;
  logic supply_ok = 1'b1;
  logic wd_ok_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  kick_watchdog #(.TIMEOUT_CYCLES(LIM)) uut (
    .clk      (clk),
    .sys_rst  (sys_rst),
    .kick_i   (kick_i),
    .supply_ok(supply_ok),
    .wd_ok_n  (wd_ok_n)
  );

  // Entry: {req[15:12], kick[11], supply[10], rst[9], wait[8:1], expect[0]}
  function automatic logic [15:0] mk(input int r, input logic k, input logic s,
                                     input logic rs, input int w, input logic e);
    return {4'(r), k, s, rs, 8'(w), e};
  endfunction

  localparam logic [15:0] VEC [NV] = '{
    mk(3, 0, 1, 1, 4,       1),  // R3 reset state
    mk(1, 0, 1, 0, LIM - 1, 1),  // R1 one cycle before expiry
    mk(1, 0, 1, 0, 1,       0),  // R1 expiry edge
    mk(4, 0, 1, 0, 5,       0),  // R4 stays asserted
    mk(2, 1, 1, 0, 2,       0),  // R2 rising change not yet effective
    mk(2, 1, 1, 0, 1,       1),  // R2 cleared on third edge
    mk(1, 1, 1, 0, LIM - 1, 1),  // R1
    mk(1, 1, 1, 0, 1,       0),  // R1
    mk(2, 0, 1, 0, 3,       1),  // R2 falling change clears
    mk(5, 0, 0, 0, 0,       0),  // R5 immediate force
    mk(5, 0, 0, 0, 5,       0),  // R5
    mk(6, 0, 1, 0, 0,       1),  // R6 immediate release
    mk(5, 0, 1, 0, LIM - 6, 1),  // R5 count kept running
    mk(5, 0, 1, 0, 1,       0),  // R5
    mk(3, 0, 1, 1, 1,       1),  // R3 reset clears expiry
    mk(3, 0, 1, 1, 2 * LIM, 1),  // R3 held clear
    mk(3, 0, 1, 0, LIM - 1, 1),  // R3 window starts at release
    mk(3, 0, 1, 0, 1,       0)   // R3
  };

  task automatic check(input logic exp, input string req, input string what);
    checks++;
    if (wd_ok_n !== exp) begin
      fails++;
      $display("FAIL %s %s: wd_ok_n=%b expected %b", req, what, wd_ok_n, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(200_000 * 8);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete");
      summary();
    end
  end

  initial begin
    @(negedge clk);
    #1;
    for (int i = 0; i < NV; i++) begin
      kick_i    = VEC[i][11];
      supply_ok = VEC[i][10];
      sys_rst   = VEC[i][9];
      wait_n(int'(VEC[i][8:1]));
      check(VEC[i][0], $sformatf("R%0d", VEC[i][15:12]), $sformatf("vector %0d", i));
    end

    // R7: service change lands on the expiry edge
    sys_rst = 1'b1;
    wait_n(4);
    sys_rst = 1'b0;
    wait_n(LIM - 3);
    kick_i = ~kick_i;
    wait_n(3);
    check(1'b1, "R7", "collision edge");
    wait_n(LIM - 1);
    check(1'b1, "R7", "new window before end");
    wait_n(1);
    check(1'b0, "R7", "new window ends");

    // R8: two-cycle pulse, timeout measured from trailing change
    kick_i = ~kick_i;
    wait_n(2);
    kick_i = ~kick_i;
    wait_n(2 + LIM);
    check(1'b1, "R8", "one before expiry");
    wait_n(1);
    check(1'b0, "R8", "expiry from trailing edge");

    // R5 during expiry, then R6 with expired timer keeps flag low
    supply_ok = 1'b0;
    wait_n(0);
    check(1'b0, "R5", "supply low while expired");
    supply_ok = 1'b1;
    wait_n(0);
    check(1'b0, "R4", "supply back, still expired");

    done = 1'b1;
    summary();
  end
endmodule